// File: doc/BRIEF.md
# Page-Bounded Stream Prefetcher

This block watches the line-granular read lookups that reach a second-level cache and spots runs of neighbouring cache lines. Lookups from data loads, data stores, first-level prefetches and instruction fetches are all treated alike. Runs may climb or fall through the line indices of a 4 KB page. Once a run is recognised, the block proposes lines further along the run, so that they can be fetched before the demand stream asks for them. It never proposes a line that lies outside the page of the lookup that caused it.

A small table of trackers holds one page each. Every tracker records the last demand line, the run direction, a training level and the next line it would propose (the frontier). Each lookup can yield up to two prefetch line addresses. They appear on two valid/address pairs in the cycle after the lookup is sampled. The frontier is never allowed to pull more than a fixed number of lines ahead of the newest demand line. A lookup to a page with no tracker takes over the least-recently-used tracker.

Top module: `strm_pf_top`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with no lookup, both prefetch valids are low.
- R2: The lookup kind code (0 load, 1 store, 2 first-level prefetch, 3 instruction fetch) has no effect on training or on the prefetches produced.
- R3: A tracker is trained by two adjacent steps in the same direction (lines i, i+1, i+2). The lookup that completes training prefetches i+3 on slot 0 and i+4 on slot 1.
- R4: A descending run (i, i-1, i-2) trains the same way and prefetches i-3 on slot 0 and i-4 on slot 1.
- R5: After training, each further adjacent step in the run direction continues from the stored frontier, so no line is proposed twice and none is skipped.
- R6: No proposed line lies more than MAX_AHEAD (default 20) lines from the demand line of its lookup. When the frontier reaches that distance, only the lines within it are issued.
- R7: A proposed line always has the page tag of its lookup. A candidate below index 0 or above index 63 is dropped, and the frontier stops at the page edge.
- R8: An adjacent step against the trained direction removes training and starts training in the new direction. The next adjacent step in that direction then prefetches afresh from the demand line.
- R9: A lookup to a non-adjacent line in the same page clears training without a prefetch. A repeated lookup to the last line produces no prefetch and leaves the tracker state unchanged.
- R10: Trackers for different pages train and prefetch independently when their lookups are interleaved.
- R11: A lookup to an untracked page allocates the least-recently-used tracker. That tracker starts untrained and produces no prefetch on that lookup.
- R12: Slot 1 is valid only when slot 0 is valid. Its line is the one adjacent to the slot-0 line, one step further along the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A monitored lookup is present this cycle |
| reqKind | input | 2 | Lookup origin code (0 load, 1 store, 2 first-level prefetch, 3 instruction fetch) |
| reqLine | input | LINE_W (30) | Line address of the lookup (byte address divided by 64) |
| pfValid0 | output | 1 | Nearer prefetch candidate valid |
| pfAddr0 | output | LINE_W (30) | Nearer prefetch line address |
| pfValid1 | output | 1 | Farther prefetch candidate valid |
| pfAddr1 | output | LINE_W (30) | Farther prefetch line address |

## Verification
The bench runs full-page runs upward from index 0 and downward from index 63, with the kind code cycling through every value. Those runs expose a design that lets the frontier drift past the 20-line reach, wraps a candidate into index 0 or 63 instead of dropping it, or reissues lines it already proposed. Reversal, gap and repeat sequences target a design that keeps stale training across a direction change, or that moves its frontier on a repeated line. A five-page sequence checks that eviction removes the stalest page and not a recently used one. A design that picked the wrong victim would either prefetch for the evicted page or lose training on a page that should have been kept.

// File: rtl/strm_pf_pkg.sv
package strm_pf_pkg;
  // 4 KB page of 64-byte lines: 64 line slots per page
  localparam int PAGE_IDX_W = 6;
  localparam int PAGE_LINES = 1 << PAGE_IDX_W;
  // frontier may step one past either page edge, so keep two extra signed bits
  localparam int FRONT_W = PAGE_IDX_W + 2;

  typedef logic [PAGE_IDX_W-1:0] lineIdx_t;
  typedef logic signed [FRONT_W-1:0] front_t;

  // strobes from the control to the tracker store
  typedef struct packed {
    logic     wrEn;    // update the selected tracker and its age
    logic     alloc;   // load a new page tag into the selected tracker
    logic     dir;     // 0 ascending, 1 descending
    logic [1:0] conf;  // 0 idle, 1 one step seen, 2 trained
    lineIdx_t last;
    front_t   next;
    logic     issue0;
    logic     issue1;
    lineIdx_t pfIdx0;
    lineIdx_t pfIdx1;
  } trkStrobe_t;
endpackage

// File: rtl/strm_pf_track_store.sv
module strm_pf_track_store
  import strm_pf_pkg::*;
#(
  parameter int TAG_W   = 24,
  parameter int NUM_TRK = 4,
  localparam int SLOT_W = (NUM_TRK > 1) ? $clog2(NUM_TRK) : 1,
  localparam int ADDR_W = TAG_W + PAGE_IDX_W
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  trkStrobe_t                        strb,
  input  logic [SLOT_W-1:0]                 slotSel,
  input  logic [TAG_W-1:0]                  reqTag,
  output logic [NUM_TRK-1:0]                trkValid,
  output logic [NUM_TRK-1:0][TAG_W-1:0]     trkTag,
  output logic [NUM_TRK-1:0]                trkDir,
  output logic [NUM_TRK-1:0][1:0]           trkConf,
  output logic [NUM_TRK-1:0][PAGE_IDX_W-1:0] trkLast,
  output logic [NUM_TRK-1:0][FRONT_W-1:0]   trkNext,
  output logic [SLOT_W-1:0]                 victim,
  output logic                              pfValid0,
  output logic [ADDR_W-1:0]                 pfAddr0,
  output logic                              pfValid1,
  output logic [ADDR_W-1:0]                 pfAddr1
);
  logic [NUM_TRK-1:0][SLOT_W-1:0] age;
  logic [NUM_TRK-1:0]             oldestVec;
  logic [SLOT_W-1:0]              selAge;

  assign selAge = age[slotSel];

  for (genvar s = 0; s < NUM_TRK; s++) begin : g_trk
    always_ff @(posedge clk) begin
      if (!rstN) begin
        trkValid[s] <= 1'b0;
        trkTag[s]   <= '0;
        trkDir[s]   <= 1'b0;
        trkConf[s]  <= 2'd0;
        trkLast[s]  <= '0;
        trkNext[s]  <= '0;
        age[s]      <= SLOT_W'(s);
      end else if (strb.wrEn) begin
        if (slotSel == SLOT_W'(s)) begin
          if (strb.alloc) begin
            trkValid[s] <= 1'b1;
            trkTag[s]   <= reqTag;
          end
          trkDir[s]  <= strb.dir;
          trkConf[s] <= strb.conf;
          trkLast[s] <= strb.last;
          trkNext[s] <= strb.next;
          age[s]     <= '0;
        end else if (age[s] < selAge) begin
          age[s] <= age[s] + 1'b1;
        end
      end
    end
    assign oldestVec[s] = (age[s] == SLOT_W'(NUM_TRK - 1));
  end

  always_comb begin
    victim = '0;
    for (int s = 0; s < NUM_TRK; s++) begin
      if (oldestVec[s]) victim = SLOT_W'(s);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfValid0 <= 1'b0;
      pfValid1 <= 1'b0;
      pfAddr0  <= '0;
      pfAddr1  <= '0;
    end else begin
      pfValid0 <= strb.issue0;
      pfValid1 <= strb.issue1;
      if (strb.issue0) pfAddr0 <= {reqTag, strb.pfIdx0};
      if (strb.issue1) pfAddr1 <= {reqTag, strb.pfIdx1};
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rstN)
    $countones(oldestVec) == 1); // R11
  AST_SLOT1_AFTER_SLOT0: assert property (@(posedge clk) disable iff (!rstN)
    pfValid1 |-> pfValid0); // R12
  AST_SLOT1_ADJACENT: assert property (@(posedge clk) disable iff (!rstN)
    pfValid1 |-> ((pfAddr1 == pfAddr0 + 1'b1) || (pfAddr1 + 1'b1 == pfAddr0))); // R12
endmodule

// File: rtl/strm_pf_ctrl.sv
module strm_pf_ctrl
  import strm_pf_pkg::*;
#(
  parameter int LINE_W    = 30,
  parameter int NUM_TRK   = 4,
  parameter int MAX_AHEAD = 20,
  localparam int TAG_W  = LINE_W - PAGE_IDX_W,
  localparam int SLOT_W = (NUM_TRK > 1) ? $clog2(NUM_TRK) : 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               reqValid,
  input  logic [LINE_W-1:0]                  reqLine,
  input  logic [NUM_TRK-1:0]                 trkValid,
  input  logic [NUM_TRK-1:0][TAG_W-1:0]      trkTag,
  input  logic [NUM_TRK-1:0]                 trkDir,
  input  logic [NUM_TRK-1:0][1:0]            trkConf,
  input  logic [NUM_TRK-1:0][PAGE_IDX_W-1:0] trkLast,
  input  logic [NUM_TRK-1:0][FRONT_W-1:0]    trkNext,
  input  logic [SLOT_W-1:0]                  victim,
  output trkStrobe_t                         strb,
  output logic [SLOT_W-1:0]                  slotSel,
  output logic [TAG_W-1:0]                   reqTag
);
  localparam front_t ONE      = front_t'(1);
  localparam front_t MINUS1   = front_t'(-1);
  localparam front_t REACH    = front_t'(MAX_AHEAD);
  localparam front_t LAST_IDX = front_t'(PAGE_LINES - 1);

  lineIdx_t          idx;
  logic              hit;
  logic [SLOT_W-1:0] hitSlot;
  front_t idxS, lastS, nextS, stepS, aheadOld, base, c0, c1, dist0, dist1;
  logic stepUp, stepDn, dirNew, sameDir, wasTrained, ok0, ok1;

  always_comb begin
    reqTag  = reqLine[LINE_W-1:PAGE_IDX_W];
    idx     = reqLine[PAGE_IDX_W-1:0];
    hit     = 1'b0;
    hitSlot = '0;
    for (int s = 0; s < NUM_TRK; s++) begin
      if (trkValid[s] && trkTag[s] == reqTag) begin
        hit     = 1'b1;
        hitSlot = SLOT_W'(s);
      end
    end
  end

  // step detection and candidate arithmetic on the hit tracker
  always_comb begin
    idxS       = front_t'({2'b00, idx});
    lastS      = front_t'({2'b00, trkLast[hitSlot]});
    nextS      = front_t'(trkNext[hitSlot]);
    stepUp     = (idxS == lastS + ONE);
    stepDn     = (idxS + ONE == lastS);
    dirNew     = stepDn;
    stepS      = dirNew ? MINUS1 : ONE;
    sameDir    = (trkConf[hitSlot] != 2'd0) && (trkDir[hitSlot] == dirNew);
    wasTrained = (trkConf[hitSlot] == 2'd2) && (trkDir[hitSlot] == dirNew);
    aheadOld   = dirNew ? (idxS - nextS) : (nextS - idxS);
    base       = (wasTrained && aheadOld > 0) ? nextS : (idxS + stepS);
    c0         = base;
    c1         = base + stepS;
    dist0      = dirNew ? (idxS - c0) : (c0 - idxS);
    dist1      = dist0 + ONE;
    ok0        = sameDir && (c0 >= 0) && (c0 <= LAST_IDX) && (dist0 <= REACH);
    ok1        = ok0 && (c1 >= 0) && (c1 <= LAST_IDX) && (dist1 <= REACH);
  end

  always_comb begin
    strb    = '0;
    slotSel = victim;
    if (reqValid) begin
      strb.wrEn = 1'b1;
      strb.last = idx;
      if (!hit) begin
        strb.alloc = 1'b1;
      end else begin
        slotSel   = hitSlot;
        strb.dir  = trkDir[hitSlot];
        strb.conf = trkConf[hitSlot];
        strb.next = nextS;
        if (stepUp || stepDn) begin
          strb.dir    = dirNew;
          strb.conf   = sameDir ? 2'd2 : 2'd1;
          strb.issue0 = ok0;
          strb.issue1 = ok1;
          strb.pfIdx0 = c0[PAGE_IDX_W-1:0];
          strb.pfIdx1 = c1[PAGE_IDX_W-1:0];
          if (sameDir) strb.next = ok1 ? (c1 + stepS) : (ok0 ? c1 : base);
        end else if (idx != trkLast[hitSlot]) begin
          strb.conf = 2'd0;
        end
      end
    end
  end

  AST_ISSUE_NEEDS_TRAINING: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue0 |-> (reqValid && hit && trkConf[hitSlot] != 2'd0)); // R3
  AST_MISS_ALLOCATES_QUIETLY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !hit) |-> (strb.alloc && !strb.issue0 && slotSel == victim)); // R11
endmodule

// File: rtl/strm_pf_top.sv
module strm_pf_top
  import strm_pf_pkg::*;
#(
  parameter int LINE_W    = 30,
  parameter int NUM_TRK   = 4,
  parameter int MAX_AHEAD = 20,
  localparam int TAG_W  = LINE_W - PAGE_IDX_W,
  localparam int SLOT_W = (NUM_TRK > 1) ? $clog2(NUM_TRK) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [LINE_W-1:0] reqLine,
  output logic              pfValid0,
  output logic [LINE_W-1:0] pfAddr0,
  output logic              pfValid1,
  output logic [LINE_W-1:0] pfAddr1
);
  trkStrobe_t                         strb;
  logic [SLOT_W-1:0]                  slotSel;
  logic [SLOT_W-1:0]                  victim;
  logic [TAG_W-1:0]                   reqTag;
  logic [NUM_TRK-1:0]                 trkValid;
  logic [NUM_TRK-1:0][TAG_W-1:0]      trkTag;
  logic [NUM_TRK-1:0]                 trkDir;
  logic [NUM_TRK-1:0][1:0]            trkConf;
  logic [NUM_TRK-1:0][PAGE_IDX_W-1:0] trkLast;
  logic [NUM_TRK-1:0][FRONT_W-1:0]    trkNext;

  strm_pf_ctrl #(.LINE_W(LINE_W), .NUM_TRK(NUM_TRK), .MAX_AHEAD(MAX_AHEAD)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLine(reqLine),
    .trkValid(trkValid), .trkTag(trkTag), .trkDir(trkDir), .trkConf(trkConf),
    .trkLast(trkLast), .trkNext(trkNext), .victim(victim),
    .strb(strb), .slotSel(slotSel), .reqTag(reqTag)
  );

  strm_pf_track_store #(.TAG_W(TAG_W), .NUM_TRK(NUM_TRK)) store_i (
    .clk(clk), .rstN(rstN), .strb(strb), .slotSel(slotSel), .reqTag(reqTag),
    .trkValid(trkValid), .trkTag(trkTag), .trkDir(trkDir), .trkConf(trkConf),
    .trkLast(trkLast), .trkNext(trkNext), .victim(victim),
    .pfValid0(pfValid0), .pfAddr0(pfAddr0), .pfValid1(pfValid1), .pfAddr1(pfAddr1)
  );

  // distance of each output from the lookup sampled one edge earlier
  logic [LINE_W-1:0]     prevLine;
  logic [PAGE_IDX_W-1:0] prevIdx, idx0, idx1, gap0, gap1;
  always_ff @(posedge clk) prevLine <= reqLine;
  always_comb begin
    prevIdx = prevLine[PAGE_IDX_W-1:0];
    idx0    = pfAddr0[PAGE_IDX_W-1:0];
    idx1    = pfAddr1[PAGE_IDX_W-1:0];
    gap0    = (idx0 > prevIdx) ? (idx0 - prevIdx) : (prevIdx - idx0);
    gap1    = (idx1 > prevIdx) ? (idx1 - prevIdx) : (prevIdx - idx1);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!pfValid0 && !pfValid1)); // R1
  AST_KIND_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !$isunknown(reqKind)); // R2
  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    pfValid0 |-> (pfAddr0[LINE_W-1:PAGE_IDX_W] == prevLine[LINE_W-1:PAGE_IDX_W])); // R7
  AST_WITHIN_REACH: assert property (@(posedge clk) disable iff (!rstN)
    pfValid0 |-> (gap0 != '0 && 32'(gap0) <= MAX_AHEAD &&
                  (!pfValid1 || (gap1 != '0 && 32'(gap1) <= MAX_AHEAD)))); // R6
endmodule

// File: tb/strm_pf_top_tb_top.sv
module strm_pf_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W     = 30;
  localparam int REACH      = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic [LINE_W-1:0] reqLine = '0;
  logic pfValid0, pfValid1;
  logic [LINE_W-1:0] pfAddr0, pfAddr1;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  typedef struct {
    bit v0; logic [LINE_W-1:0] a0;
    bit v1; logic [LINE_W-1:0] a1;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  strm_pf_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqLine(reqLine),
    .pfValid0(pfValid0), .pfAddr0(pfAddr0), .pfValid1(pfValid1), .pfAddr1(pfAddr1)
  );

  function automatic logic [LINE_W-1:0] lineOf(int page, int idx);
    return LINE_W'(page * 64 + idx);
  endfunction

  // driver: present one lookup and queue the expected prefetches
  task automatic lookup(int page, int idx, int kind, bit v0, int i0, bit v1, int i1, string tag);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1;
    reqKind  = 2'(kind);
    reqLine  = lineOf(page, idx);
    e.v0 = v0; e.a0 = lineOf(page, i0);
    e.v1 = v1; e.a1 = lineOf(page, i1);
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idleCheck(string tag);
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    testCount++;
    if (pfValid0 || pfValid1) begin
      failCount++;
      $display("FAIL %s: valids %0b%0b expected 00", tag, pfValid0, pfValid1);
    end
  endtask

  // monitor: compare the cycle after each sampled lookup
  initial begin
    forever begin
      bit had;
      exp_t e;
      @(posedge clk);
      had = reqValid;
      #(CLK_PERIOD/4);
      if (had) begin
        testCount++;
        if (expQ.size() == 0) begin
          failCount++;
          $display("FAIL scoreboard: output with no expectation");
        end else begin
          e = expQ.pop_front();
          if (pfValid0 !== e.v0 || pfValid1 !== e.v1 ||
              (e.v0 && pfAddr0 !== e.a0) || (e.v1 && pfAddr1 !== e.a1)) begin
            failCount++;
            $display("FAIL %s: got v0=%0b a0=%0h v1=%0b a1=%0h, expected v0=%0b a0=%0h v1=%0b a1=%0h",
                     e.tag, pfValid0, pfAddr0, pfValid1, pfAddr1, e.v0, e.a0, e.v1, e.a1);
          end
        end
      end
    end
  end

  // full-page run; expectations follow R3..R7 by position along the run
  task automatic runStream(int page, int start, bit down, string tag);
    int front = 0;
    for (int k = 0; k < 64; k++) begin
      int idx = down ? start - k : start + k;
      bit v0 = 1'b0, v1 = 1'b0;
      int i0 = 0, i1 = 0;
      if (k >= 2) begin
        if (k == 2) front = 3;
        i0 = down ? start - front : start + front;
        i1 = down ? i0 - 1 : i0 + 1;
        v0 = (i0 >= 0 && i0 <= 63 && front - k <= REACH);
        v1 = v0 && (i1 >= 0 && i1 <= 63 && front + 1 - k <= REACH);
        front += int'(v0) + int'(v1);
      end
      lookup(page, idx, k % 4, v0, i0, v1, i1, tag);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCount++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testCount++;
    if (pfValid0 || pfValid1) begin
      failCount++;
      $display("FAIL R1 reset: valids %0b%0b expected 00", pfValid0, pfValid1);
    end

    // R3 R5 R6 R7 R2: ascending full page with all kind codes
    runStream(5, 0, 1'b0, "R3/R5/R6/R7/R2 ascending");
    // R4 R6 R7: descending full page
    runStream(9, 63, 1'b1, "R4/R6/R7 descending");
    idleCheck("R1 idle after lookups");

    // R8 reversal
    lookup(12, 10, 0, 0, 0, 0, 0, "R8 alloc");
    lookup(12, 11, 1, 0, 0, 0, 0, "R8 step");
    lookup(12, 12, 2, 1, 13, 1, 14, "R8 trained up");
    lookup(12, 11, 3, 0, 0, 0, 0, "R8 reverse step no prefetch");
    lookup(12, 10, 0, 1, 9, 1, 8, "R8 retrained down");

    // R9 gap and repeat
    lookup(14, 20, 0, 0, 0, 0, 0, "R9 alloc");
    lookup(14, 21, 0, 0, 0, 0, 0, "R9 step");
    lookup(14, 25, 0, 0, 0, 0, 0, "R9 gap clears training");
    lookup(14, 26, 0, 0, 0, 0, 0, "R9 step after gap");
    lookup(14, 27, 0, 1, 28, 1, 29, "R9 retrained");
    lookup(14, 27, 0, 0, 0, 0, 0, "R9 repeat no prefetch");
    lookup(14, 28, 0, 1, 30, 1, 31, "R9 repeat left frontier");

    // R10 interleaved pages
    lookup(20, 40, 1, 0, 0, 0, 0, "R10 a0");
    lookup(21, 50, 2, 0, 0, 0, 0, "R10 b0");
    lookup(20, 39, 3, 0, 0, 0, 0, "R10 a1");
    lookup(21, 51, 0, 0, 0, 0, 0, "R10 b1");
    lookup(20, 38, 1, 1, 37, 1, 36, "R10 a trained down");
    lookup(21, 52, 2, 1, 53, 1, 54, "R10 b trained up");

    // R11 LRU eviction
    lookup(30, 0, 0, 0, 0, 0, 0, "R11 p30 alloc");
    lookup(30, 1, 0, 0, 0, 0, 0, "R11 p30 step");
    lookup(31, 0, 0, 0, 0, 0, 0, "R11 p31 alloc");
    lookup(32, 0, 0, 0, 0, 0, 0, "R11 p32 alloc");
    lookup(33, 0, 0, 0, 0, 0, 0, "R11 p33 alloc");
    lookup(34, 0, 0, 0, 0, 0, 0, "R11 p34 evicts p30");
    lookup(31, 1, 0, 0, 0, 0, 0, "R11 p31 kept step");
    lookup(31, 2, 0, 1, 3, 1, 4, "R11 p31 kept trained");
    lookup(30, 2, 0, 0, 0, 0, 0, "R11 p30 lost training");

    idleCheck("R1 idle at end");
    if (expQ.size() != 0) begin
      testCount++;
      failCount++;
      $display("FAIL scoreboard: %0d expectations left, expected 0", expQ.size());
    end
    finishRun();
  end
endmodule